// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Write Front-End

This block is the receive side of a serial EEPROM slave on a two-wire bus, covering write commands only. It samples the bus clock and data lines with the system clock and finds start and stop conditions. It then shifts in a control byte, two word-address bytes and any number of data bytes. After each byte it accepts, it pulls the data line low for the acknowledge clock. It keeps the word-address pointer and passes every data byte, with its target address, to a page buffer that sits outside the block.

A stop that closes a command carrying at least one data byte starts the internal write cycle. The cycle is modelled as a busy window of a fixed number of system clocks. While that window is open the slave stays silent and acknowledges nothing, not even its own control byte. If the write-protect input is high when the stop arrives, the command has still been acknowledged in full, but no write cycle starts and the slave is ready for a new command at once.

Top module: `eeprom_wr_front`

## Requirements
- R1: A falling data line while the clock line is high opens a new command. The slave acknowledges a matching control byte. The control byte is sent MSB first: bits 7..4 are 1010, bits 3..1 equal cs_pins[2:0], and bit 0 is 0 (write). The acknowledge is sda_drive_low set after the clock falls at the end of bit 8. It is held through the ninth clock and cleared after the ninth clock falls.
- R2: The slave does not acknowledge a control byte whose code is not 1010, whose select bits differ from cs_pins, or whose bit 0 is 1. After such a byte it does not acknowledge any further byte until the next start.
- R3: The slave acknowledges the first byte after the control byte and loads its low 6 bits into pointer bits 13..8; its top 2 bits are ignored. It acknowledges the second byte and loads it into pointer bits 7..0.
- R4: The slave acknowledges each data byte. For each one, wr_valid is high for exactly one clock, with wr_data set to the byte and wr_addr set to the pointer value before the increment.
- R5: After each data byte, pointer bits 5..0 increase by one and wrap from 63 to 0. Pointer bits 13..6 do not change.
- R6: A stop that follows at least one data byte, with wp_in low, gives a one-clock cycle_start pulse. busy is then high for exactly BUSY_CYCLES clocks.
- R7: While busy is high the slave acknowledges no byte, including a matching control byte, and wr_valid stays low.
- R8: If wp_in is high when the stop is seen, every byte of the command is still acknowledged. No cycle_start occurs, busy stays low, and a following command is acknowledged at once.
- R9: A stop before any data byte, for example one that follows only the address bytes, gives no cycle_start.
- R10: After reset, sda_drive_low, busy, wr_valid and cycle_start are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line sample (asynchronous) |
| sda_in | input | 1 | Bus data line sample (asynchronous) |
| cs_pins | input | 3 | Hardware chip-select strap pins |
| wp_in | input | 1 | Write-protect, sampled at the stop |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls the data line low |
| ptr_o | output | ADDR_W | Current word-address pointer |
| wr_valid | output | 1 | One-clock strobe for a received data byte |
| wr_addr | output | ADDR_W | Page-buffer address of the data byte |
| wr_data | output | 8 | Received data byte |
| cycle_start | output | 1 | One-clock pulse that starts the internal write cycle |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Most faults in the byte state or the bit count show up on sda_drive_low at the very next acknowledge clock, so the bench checks the data line at both halves of every ninth clock. A wrong pointer appears as a wrong wr_addr on the next data byte, or as a wrong ptr_o at the end of the command. A fault in the busy counter or in the write-protect sampling changes the busy length or the cycle_start count within one command. It also shows up as an unexpected acknowledge in a command sent during the busy window.

// File: rtl/eep_wr_pkg.sv
package eep_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR_H,
    ST_ADDR_L,
    ST_DATA
  } wr_state_t;

  localparam logic [3:0] CTRL_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_bit,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;
  logic scl_s, sda_s;

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh    <= '1;
      sda_sh    <= '1;
      scl_prev  <= 1'b1;
      sda_prev  <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      sda_bit   <= 1'b1;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_sh    <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh    <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_prev  <= scl_s;
      sda_prev  <= sda_s;
      scl_rise  <= scl_s & ~scl_prev;
      scl_fall  <= ~scl_s & scl_prev;
      sda_bit   <= sda_s;
      start_det <= scl_s & scl_prev & sda_prev & ~sda_s;
      stop_det  <= scl_s & scl_prev & ~sda_prev & sda_s;
    end
  end
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (start_i)       cnt <= CNT_W'(CYCLES);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i)); // R6
endmodule

// File: rtl/eep_wr_fsm.sv
module eep_wr_fsm
  import eep_wr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_bit,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        cs_pins,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              drive_low,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              cycle_start
);
  localparam int HI_W = ADDR_W - 8;

  wr_state_t   state;
  logic [7:0]  shreg;
  logic [3:0]  bitcnt;
  logic        in_ack;
  logic        got_data;
  logic        ctrl_ok;

  assign ctrl_ok = (shreg[7:4] == CTRL_CODE) && (shreg[3:1] == cs_pins) &&
                   !shreg[0] && !busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      shreg       <= '0;
      bitcnt      <= '0;
      in_ack      <= 1'b0;
      got_data    <= 1'b0;
      drive_low   <= 1'b0;
      ptr_o       <= '0;
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      cycle_start <= 1'b0;
    end else begin
      wr_valid    <= 1'b0;
      cycle_start <= 1'b0;
      if (start_det) begin
        state     <= ST_CTRL;
        bitcnt    <= '0;
        in_ack    <= 1'b0;
        drive_low <= 1'b0;
        got_data  <= 1'b0;
      end else if (stop_det) begin
        if (state == ST_DATA && got_data && !wp_i) cycle_start <= 1'b1;
        state     <= ST_IDLE;
        in_ack    <= 1'b0;
        drive_low <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise && !in_ack && bitcnt != 4'd8) begin
          shreg  <= {shreg[6:0], sda_bit};
          bitcnt <= bitcnt + 1'b1;
        end
        if (scl_fall) begin
          if (in_ack) begin
            drive_low <= 1'b0;
            in_ack    <= 1'b0;
            bitcnt    <= '0;
          end else if (bitcnt == 4'd8) begin
            case (state)
              ST_CTRL: begin
                if (ctrl_ok) begin
                  drive_low <= 1'b1;
                  in_ack    <= 1'b1;
                  state     <= ST_ADDR_H;
                end else begin
                  state     <= ST_IDLE;
                end
              end
              ST_ADDR_H: begin
                ptr_o[ADDR_W-1:8] <= shreg[HI_W-1:0];
                drive_low <= 1'b1;
                in_ack    <= 1'b1;
                state     <= ST_ADDR_L;
              end
              ST_ADDR_L: begin
                ptr_o[7:0] <= shreg;
                drive_low  <= 1'b1;
                in_ack     <= 1'b1;
                state      <= ST_DATA;
              end
              ST_DATA: begin
                wr_valid  <= 1'b1;
                wr_data   <= shreg;
                wr_addr   <= ptr_o;
                ptr_o[PAGE_W-1:0] <= ptr_o[PAGE_W-1:0] + 1'b1;
                got_data  <= 1'b1;
                drive_low <= 1'b1;
                in_ack    <= 1'b1;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !drive_low); // R7
  AST_ACK_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_low) |-> $past(scl_fall)); // R1
  AST_WR_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid); // R4
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (ptr_o[PAGE_W-1:0] == PAGE_W'($past(ptr_o[PAGE_W-1:0]) + 1'b1)) &&
                 (ptr_o[ADDR_W-1:PAGE_W] == $past(ptr_o[ADDR_W-1:PAGE_W]))); // R5
  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> !$past(wp_i)); // R8
  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> !busy_i); // R6
endmodule

// File: rtl/eeprom_wr_front.sv
module eeprom_wr_front #(
  parameter int ADDR_W      = 14,
  parameter int PAGE_W      = 6,
  parameter int BUSY_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        cs_pins,
  input  logic              wp_in,
  output logic              sda_drive_low,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              cycle_start,
  output logic              busy
);
  logic scl_rise, scl_fall, sda_bit, start_det, stop_det;

  eep_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_in), .sda_i(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_bit(sda_bit),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_wr_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_bit(sda_bit), .start_det(start_det), .stop_det(stop_det),
    .cs_pins(cs_pins), .wp_i(wp_in), .busy_i(busy),
    .drive_low(sda_drive_low), .ptr_o(ptr_o), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .cycle_start(cycle_start)
  );

  eep_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start_i(cycle_start), .busy_o(busy)
  );
endmodule

// File: tb/sim_eeprom_wr_front.sv
`timescale 1ns/1ps
module sim_eeprom_wr_front;
  localparam int BUSY = 400;
  localparam int H    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [2:0] cs = 3'b101;
  logic wp = 1'b0;
  logic sda_in;
  logic drive, wr_valid, cycle_start, busy;
  logic [13:0] ptr, wr_addr;
  logic [7:0] wr_data;

  always #2 clk = ~clk;
  assign sda_in = sda_m & ~drive;

  eeprom_wr_front #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_in), .cs_pins(cs),
    .wp_in(wp), .sda_drive_low(drive), .ptr_o(ptr), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .cycle_start(cycle_start), .busy(busy)
  );

  int checks = 0, errors = 0, n_cs = 0, busy_len = 0;
  logic [21:0] exp_q[$], got_q[$];
  logic [13:0] m_ptr = '0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural observation of strobes, every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid) got_q.push_back({wr_addr, wr_data});
      if (cycle_start) n_cs++;
      if (busy) busy_len++;
    end
  end

  task automatic wait_h(); repeat (H) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; wait_h();
    sda_m = 1'b0; wait_h();
    scl = 1'b0; wait_h();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_h();
    scl = 1'b1; wait_h();
    sda_m = 1'b1; wait_h();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_h(); scl = 1'b1; wait_h(); scl = 1'b0;
    end
    sda_m = 1'b1; wait_h();
    chk(req, drive, exp_ack);
    scl = 1'b1; wait_h();
    chk(req, drive, exp_ack);
    scl = 1'b0; wait_h();
    chk(req, drive, 0);
  endtask

  task automatic send_data(input logic [7:0] b, input logic exp_ack, input string req);
    send_byte(b, exp_ack, req);
    if (exp_ack) begin
      exp_q.push_back({m_ptr, b});
      m_ptr[5:0] = m_ptr[5:0] + 6'd1;
    end
  endtask

  task automatic send_addr(input logic [7:0] hi, input logic [7:0] lo);
    send_byte(hi, 1'b1, "R3");
    send_byte(lo, 1'b1, "R3");
    m_ptr = {hi[5:0], lo};
  endtask

  task automatic cmp_q(input string req);
    chk(req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(req, got_q[i], exp_q[i]);
    exp_q.delete(); got_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", drive, 0); chk("R10", busy, 0);
    chk("R10", ptr, 0);   chk("R10", wr_valid, 0);
    chk("R10", cycle_start, 0);

    // page write with a high byte whose top bits are set, wrapping inside the page
    bus_start();
    send_byte(8'b1010_101_0, 1'b1, "R1");
    send_addr(8'hC5, 8'h3E);
    send_data(8'h11, 1'b1, "R4");
    send_data(8'h22, 1'b1, "R4");
    send_data(8'h33, 1'b1, "R5");
    chk("R5", ptr, 14'h0501);
    cmp_q("R4");
    busy_len = 0;
    bus_stop();
    chk("R6", n_cs, 1);
    chk("R6", busy, 1);

    // command during the write cycle is ignored
    bus_start();
    send_byte(8'b1010_101_0, 1'b0, "R7");
    bus_stop();
    chk("R7", busy, 1);
    cmp_q("R7");
    while (busy) @(negedge clk);
    chk("R6", busy_len, BUSY);

    // mismatching control bytes
    bus_start();
    send_byte(8'b1010_011_0, 1'b0, "R2");
    send_byte(8'hFF, 1'b0, "R2");
    bus_stop();
    bus_start();
    send_byte(8'b1011_101_0, 1'b0, "R2");
    bus_stop();
    bus_start();
    send_byte(8'b1010_101_1, 1'b0, "R2");
    bus_stop();
    cmp_q("R2");
    chk("R2", n_cs, 1);

    // write-protected command: acked, no cycle
    wp = 1'b1;
    bus_start();
    send_byte(8'b1010_101_0, 1'b1, "R8");
    send_addr(8'h12, 8'h34);
    send_data(8'hAB, 1'b1, "R8");
    bus_stop();
    chk("R8", n_cs, 1);
    chk("R8", busy, 0);
    cmp_q("R8");
    wp = 1'b0;

    // immediately accepted; stop after address only
    bus_start();
    send_byte(8'b1010_101_0, 1'b1, "R8");
    send_addr(8'h00, 8'h10);
    bus_stop();
    chk("R9", n_cs, 1);
    chk("R9", busy, 0);
    chk("R3", ptr, 14'h0010);

    // single byte write, different chip select
    cs = 3'b010;
    bus_start();
    send_byte(8'b1010_010_0, 1'b1, "R1");
    send_addr(8'h00, 8'h20);
    send_data(8'h5A, 1'b1, "R4");
    busy_len = 0;
    bus_stop();
    chk("R5", ptr, 14'h0021);
    chk("R6", n_cs, 2);
    cmp_q("R4");
    while (busy) @(negedge clk);
    chk("R6", busy_len, BUSY);

    finish_run();
  end
endmodule